// File: doc/BRIEF.md
# Supervisory Reset and Bus-Watchdog Controller

This block produces one system reset from three causes: the chip-level power-on reset, a digital low-supply flag from an analog comparator, and a watchdog that expires when the two-wire bus shows no start-style activity. The watchdog is never kicked through a dedicated pin. It restarts only when the synchronized SDA line falls while the synchronized SCL line is high, so normal bus transactions keep the system alive. A hung host that stops talking on the bus is reset.

All durations are counted in cycles of a clock-enable input `tick`, scaled by `TICKS_PER_MS`. A bench can therefore shrink every interval. The watchdog interval is picked by a 2-bit selection input and is captured once after reset release. The polarity of the reset output is a parameter.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `low_supply` is 1, the reset output is active in the same cycle, through combinational logic only.
- R2: After `low_supply` returns to 0, the reset output stays active until HOLD_MS*TICKS_PER_MS tick cycles have passed with `low_supply` 0. It goes inactive on the clock edge of the last such tick.
- R3: While `rst_n` is 0, the reset output is active. After `rst_n` is released, it goes inactive on the edge of the HOLD_MS*TICKS_PER_MS-th tick.
- R4: A watchdog restart happens only when the synchronized SDA goes from 1 to 0 while the synchronized SCL is 1. Each input passes through two flops and the restart takes effect two edges after the first edge that sees the fall. An SDA fall while SCL is low does not restart the watchdog.
- R5: If the watchdog is enabled and sees no restart for the selected number of ticks after its last reload, the reset output is asserted on the edge of the last tick. It is then held for the same hold period as R2, and the watchdog starts again from zero.
- R6: `wd_sel` encoding: 0 = watchdog off (it never expires), 1 = WD_SHORT_MS, 2 = WD_MED_MS, 3 = WD_LONG_MS, each multiplied by TICKS_PER_MS.
- R7: `wd_sel` is captured on the first clock edge after `rst_n` is released. Later changes have no effect until the next `rst_n` assertion.
- R8: With ACTIVE_HIGH=1 the output is 1 when reset is active. With ACTIVE_HIGH=0 it is 0 when active.
- R9: A new `low_supply` assertion during a hold period restarts the hold count from zero.
- R10: Hold and watchdog counters advance only on cycles where `tick` is 1.
- R11: The watchdog does not count while reset is active. A full interval begins on the edge where the hold ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously |
| tick | input | 1 | Time-base clock enable |
| low_supply | input | 1 | Supply-below-threshold flag, active high |
| scl_in | input | 1 | Bus clock line, sampled |
| sda_in | input | 1 | Bus data line, sampled |
| wd_sel | input | 2 | Watchdog interval selection (R6) |
| reset_out | output | 1 | System reset, polarity set by ACTIVE_HIGH |

## Verification
**Low supply.** Reset follows a rising `low_supply` with no clock edge in between, so the bench samples it one nanosecond after driving the flag. Release after the flag clears is due on the tenth tick edge in the bench configuration. The bench therefore checks one cycle before that edge (still active) and on it (released).

**Watchdog.** Expiry lands on the edge of the last interval tick after the hold ends. A bus restart needs two synchronizer stages plus the edge-history flop, so it reloads the counter on the third edge after SDA falls. Kick scenarios are timed so that the expiry with and without the restart falls in different sampled cycles.

**Sampling.** Every check samples at a falling edge, after the effects of the preceding rising edge have settled. The bench counts edges from a known release edge.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    WD_OFF   = 2'd0,
    WD_SHORT = 2'd1,
    WD_MED   = 2'd2,
    WD_LONG  = 2'd3
  } wd_sel_e;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/sup_start_det.sv
module sup_start_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic kick
);
  logic sda_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_prev_q <= 1'b1;
    else        sda_prev_q <= sda_s;
  end

  assign kick = sda_prev_q & ~sda_s & scl_s;

  // R4
  kick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !kick);
endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
  parameter int HOLD_TICKS = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic low_supply,
  input  logic wd_expire,
  output logic hold_act
);
  localparam int HCW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam logic [HCW-1:0] LAST = HCW'(HOLD_TICKS - 1);

  logic [HCW-1:0] cnt_q, cnt_d;
  logic           act_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = hold_act;
    if (low_supply || wd_expire) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (hold_act && tick) begin
      if (cnt_q == LAST) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + HCW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_act <= 1'b1;
      cnt_q    <= '0;
    end else begin
      hold_act <= act_d;
      cnt_q    <= cnt_d;
    end
  end

  // R9
  low_restarts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_supply |=> (hold_act && cnt_q == '0));

  // R2
  release_on_good_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_act) |-> (!$past(low_supply) && $past(tick)));

  // R10
  hold_frozen_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !low_supply && !wd_expire) |=> $stable(cnt_q));
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
  import sup_pkg::*;
#(
  parameter int SHORT_T = 200,
  parameter int MED_T   = 600,
  parameter int LONG_T  = 1400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] wd_sel,
  input  logic       kick,
  input  logic       rst_act,
  output logic       expire
);
  localparam int MAX_SM = (SHORT_T > MED_T) ? SHORT_T : MED_T;
  localparam int MAX_T  = (MAX_SM > LONG_T) ? MAX_SM : LONG_T;
  localparam int WCW    = $clog2(MAX_T + 1);

  logic           cfg_loaded;
  wd_sel_e        cfg_sel;
  logic [WCW-1:0] cnt_q, cnt_d, limit;
  logic           run;

  always_comb begin
    case (cfg_sel)
      WD_SHORT: limit = WCW'(SHORT_T);
      WD_MED:   limit = WCW'(MED_T);
      WD_LONG:  limit = WCW'(LONG_T);
      default:  limit = '0;
    endcase
  end

  assign run    = cfg_loaded && (cfg_sel != WD_OFF) && !rst_act;
  assign expire = run && tick && !kick && (cnt_q == limit - WCW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run || kick || expire) cnt_d = '0;
    else if (tick)              cnt_d = cnt_q + WCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_loaded <= 1'b0;
      cfg_sel    <= WD_OFF;
      cnt_q      <= '0;
    end else begin
      if (!cfg_loaded) begin
        cfg_loaded <= 1'b1;
        cfg_sel    <= wd_sel_e'(wd_sel);
      end
      cnt_q <= cnt_d;
    end
  end

  // R5
  wd_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < limit));

  // R7
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_loaded |=> $stable(cfg_sel));

  // R11
  no_count_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_act |=> (cnt_q == '0));

  // R6
  off_never_expires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_loaded && cfg_sel == WD_OFF) |-> !expire);
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
  parameter int TICKS_PER_MS = 1,
  parameter int HOLD_MS      = 250,
  parameter int WD_SHORT_MS  = 200,
  parameter int WD_MED_MS    = 600,
  parameter int WD_LONG_MS   = 1400,
  parameter bit ACTIVE_HIGH  = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       low_supply,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] wd_sel,
  output logic       reset_out
);
  localparam int HOLD_TICKS = HOLD_MS * TICKS_PER_MS;
  localparam int SHORT_T    = WD_SHORT_MS * TICKS_PER_MS;
  localparam int MED_T      = WD_MED_MS * TICKS_PER_MS;
  localparam int LONG_T     = WD_LONG_MS * TICKS_PER_MS;

  logic [1:0] bus_s;
  logic       kick, wd_expire, hold_act, rst_act;

  sup_sync #(.W(2), .RST_VAL(2'b11)) u_bus_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_in, sda_in}),
    .q     (bus_s)
  );

  sup_start_det u_start_det (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_s (bus_s[1]),
    .sda_s (bus_s[0]),
    .kick  (kick)
  );

  sup_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .low_supply (low_supply),
    .wd_expire  (wd_expire),
    .hold_act   (hold_act)
  );

  assign rst_act = low_supply | hold_act;

  sup_wdog #(.SHORT_T(SHORT_T), .MED_T(MED_T), .LONG_T(LONG_T)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wd_sel  (wd_sel),
    .kick    (kick),
    .rst_act (rst_act),
    .expire  (wd_expire)
  );

  generate
    if (ACTIVE_HIGH) begin : g_pol_hi
      assign reset_out = rst_act;
    end else begin : g_pol_lo
      assign reset_out = ~rst_act;
    end
  endgenerate

  // R5
  expire_asserts_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> rst_act);
endmodule

// File: tb/sup_reset_ctrl_bench.sv
module sup_reset_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n, tick, low_supply, scl_in, sda_in;
  logic [1:0] wd_sel;
  logic       rst_hi, rst_lo;
  int         n_chk = 0;
  int         n_err = 0;

  always #10 clk = ~clk;

  sup_reset_ctrl #(.TICKS_PER_MS(2), .HOLD_MS(5), .WD_SHORT_MS(3), .WD_MED_MS(6),
    .WD_LONG_MS(12), .ACTIVE_HIGH(1'b1)) u_sup_reset_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .low_supply(low_supply),
    .scl_in(scl_in), .sda_in(sda_in), .wd_sel(wd_sel), .reset_out(rst_hi));

  sup_reset_ctrl #(.TICKS_PER_MS(2), .HOLD_MS(5), .WD_SHORT_MS(3), .WD_MED_MS(6),
    .WD_LONG_MS(12), .ACTIVE_HIGH(1'b0)) u_sup_reset_ctrl_lo (
    .clk(clk), .rst_n(rst_n), .tick(tick), .low_supply(low_supply),
    .scl_in(scl_in), .sda_in(sda_in), .wd_sel(wd_sel), .reset_out(rst_lo));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic exp, input string tag);
    #1;
    n_chk++;
    if (rst_hi !== exp) begin
      n_err++;
      $display("FAIL %s: reset_out(high) actual %b expected %b at %0t", tag, rst_hi, exp, $time);
    end
    n_chk++;
    if (rst_lo !== ~exp) begin
      n_err++;
      $display("FAIL R8 (%s): reset_out(low) actual %b expected %b", tag, rst_lo, ~exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] sel);
    @(negedge clk);
    rst_n = 1'b0; wd_sel = sel; low_supply = 1'b0;
    scl_in = 1'b1; sda_in = 1'b1; tick = 1'b1;
    step(2);
    chk(1'b1, "R3 during rst_n");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_power_on();
    do_reset(2'd0);
    step(9);  chk(1'b1, "R3 hold before last tick");
    step(1);  chk(1'b0, "R3 release on last tick");
  endtask

  task automatic t_tick_gap();
    do_reset(2'd0);
    for (int k = 1; k <= 19; k++) begin
      @(negedge clk);
      tick = (k % 2 == 0);
      if (k == 18) chk(1'b1, "R10 gapped tick hold");
      if (k == 19) chk(1'b0, "R10 gapped tick release");
    end
    tick = 1'b1;
  endtask

  task automatic t_low_supply();
    do_reset(2'd0);
    step(10); chk(1'b0, "R3 up");
    @(negedge clk); low_supply = 1'b1;
    chk(1'b1, "R1 immediate assert");
    step(3); low_supply = 1'b0;
    step(9); chk(1'b1, "R2 hold after flag clears");
    step(1); chk(1'b0, "R2 release after good period");
  endtask

  task automatic t_low_retrigger();
    do_reset(2'd0);
    step(10);
    @(negedge clk); low_supply = 1'b1;
    step(2); low_supply = 1'b0;
    step(5); chk(1'b1, "R9 mid hold");
    low_supply = 1'b1;
    step(1); low_supply = 1'b0;
    step(9); chk(1'b1, "R9 hold restarted");
    step(1); chk(1'b0, "R9 release after restart");
  endtask

  task automatic t_wd_expiry();
    do_reset(2'd1);
    step(10); chk(1'b0, "R11 hold ends");
    step(5);  chk(1'b0, "R11 full interval before expiry");
    step(1);  chk(1'b1, "R5 expiry asserts");
    step(9);  chk(1'b1, "R5 expiry hold");
    step(1);  chk(1'b0, "R5 expiry hold release");
    step(5);  chk(1'b0, "R5 watchdog restarted from zero");
    step(1);  chk(1'b1, "R5 second expiry");
  endtask

  task automatic t_wd_intervals();
    do_reset(2'd2);
    step(10);
    step(11); chk(1'b0, "R6 medium before expiry");
    step(1);  chk(1'b1, "R6 medium expiry");
    do_reset(2'd3);
    step(10);
    step(23); chk(1'b0, "R6 long before expiry");
    step(1);  chk(1'b1, "R6 long expiry");
  endtask

  task automatic t_wd_off();
    logic seen;
    do_reset(2'd0);
    step(10);
    seen = 1'b0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk); #1;
      if (rst_hi !== 1'b0) seen = 1'b1;
    end
    n_chk++;
    if (seen) begin
      n_err++;
      $display("FAIL R6: watchdog off, reset seen actual 1 expected 0");
    end
  endtask

  task automatic t_cfg_latch();
    logic seen;
    do_reset(2'd1);
    step(2); wd_sel = 2'd3;
    step(8); chk(1'b0, "R7 up");
    step(5); chk(1'b0, "R7 short kept");
    step(1); chk(1'b1, "R7 short expiry despite change");
    do_reset(2'd0);
    step(2); wd_sel = 2'd1;
    step(8);
    seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); #1;
      if (rst_hi !== 1'b0) seen = 1'b1;
    end
    n_chk++;
    if (seen) begin
      n_err++;
      $display("FAIL R7: late select enabled watchdog, actual 1 expected 0");
    end
  endtask

  task automatic t_kick();
    do_reset(2'd1);
    step(10);
    step(2); sda_in = 1'b0;
    step(1); sda_in = 1'b1;
    step(7); chk(1'b0, "R4 start restarts watchdog");
    step(1); chk(1'b1, "R4 expiry after restart");
  endtask

  task automatic t_no_kick();
    do_reset(2'd1);
    step(10);
    step(2); sda_in = 1'b0; scl_in = 1'b0;
    step(1); sda_in = 1'b1; scl_in = 1'b1;
    step(2); chk(1'b0, "R4 before expiry");
    step(1); chk(1'b1, "R4 SDA fall with SCL low ignored");
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b1; low_supply = 1'b0;
    scl_in = 1'b1; sda_in = 1'b1; wd_sel = 2'd0;
    t_power_on();
    t_tick_gap();
    t_low_supply();
    t_low_retrigger();
    t_wd_expiry();
    t_wd_intervals();
    t_wd_off();
    t_cfg_latch();
    t_kick();
    t_no_kick();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R1-watchdog: run hung, actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule